// File: doc/BRIEF.md
# Interleaved Four-Bank Block Refill Controller

This controller fills one cache block from a memory built of several word-interleaved DRAM banks that share a bus one word wide. A refill request carries a block address. The controller sends that address to every bank at once in a single bus cycle, so all banks run their slow access at the same time. It then waits out the fixed access latency and reads the banks in turn. Each bus cycle, one bank drives the bus, and that word goes to the cache together with its word index and a valid strobe.

With the default settings there are four banks and a 15-cycle access. A full block therefore arrives 1 + 15 + 4 = 20 bus cycles after the address cycle starts. A single non-interleaved memory would need 65 cycles for the same block. Bank k holds every word whose word address modulo the bank count equals k. The bank at row b, for block b, therefore holds word address NBANK*b + k. The controller takes a new request only while it is idle.

Top module: `ilv_block_fetch`

## Requirements
- R1: After reset, `ready` is 1 and `bank_strobe`, `fill_valid` and `fill_done` are 0.
- R2: A request is accepted on a clock edge where `ready` and `req_valid` are both 1. In the cycle after acceptance, `bank_strobe` is 1 for exactly one cycle and `bank_addr` equals the accepted block address. Without a request, the controller stays idle and drives no strobe and no words.
- R3: `bank_addr` holds the accepted block address, unchanged, from the strobe cycle until the last word has been delivered.
- R4: The first word appears exactly LAT+1 cycles after the strobe cycle. With LAT=15, the strobe is cycle 1 and the words occupy cycles 17 to 20, so the whole refill takes 1+LAT+NBANK cycles.
- R5: Words are delivered in ascending bank order, starting at bank 0. While `fill_valid` is 1, `fill_idx` equals k, and `fill_data` equals bank k's output, which is the word at word address NBANK*block + k.
- R6: `fill_valid` is 1 for exactly NBANK consecutive cycles per request, and `fill_idx` increments by one each cycle.
- R7: `fill_done` is 1 only in the cycle that carries the last word (index NBANK-1), and it is 1 in that cycle.
- R8: A request presented while the controller is busy has no effect. The address stays the same, and no further strobe or words follow once the refill ends.
- R9: `ready` is 0 from the strobe cycle through the last-word cycle and returns to 1 in the next cycle. A request made in that cycle starts its strobe in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request |
| req_addr | input | ADDR_W | Block address of the request |
| ready | output | 1 | Controller idle; a request is accepted this cycle |
| bank_strobe | output | 1 | Broadcast address strobe to all banks |
| bank_addr | output | ADDR_W | Row (block) address broadcast to all banks |
| bank_rdata | input | NBANK*DATA_W | Read data of all banks, bank k at bits [k*DATA_W +: DATA_W] |
| fill_valid | output | 1 | A block word is on the bus toward the cache |
| fill_idx | output | $clog2(NBANK) | Word index within the block |
| fill_data | output | DATA_W | Word delivered to the cache |
| fill_done | output | 1 | Last word of the block |

## Verification
The bank models put a poison pattern on their outputs until the access latency has fully elapsed. A controller that starts reading one cycle early therefore delivers poison and fails the data check, and one that starts late shifts every word and the done pulse. Each refill uses a different block address and a different pattern per bank. This exposes a wrong bank order, an index that is off by one, or a mux that reads a stale bank. A run keeps requesting other addresses while busy, which catches a controller that reloads its address or starts a second fetch. Back-to-back refills catch a controller that needs an extra idle cycle or drops the request made in its first idle cycle.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_XFER = 2'd3
    } ilv_state_e;
endpackage

// File: rtl/ilv_seq_ctrl.sv
module ilv_seq_ctrl
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NBANK  = 4,
    parameter int LAT    = 15,
    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int CNT_W = $clog2(LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ready,
    output logic              strobe,
    output logic [ADDR_W-1:0] row_addr,
    output logic              xfer,
    output logic [IDX_W-1:0]  word_sel,
    output logic              last_word
);
    typedef struct packed {
        ilv_state_e        state;
        logic [CNT_W-1:0]  wait_cnt;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NBANK - 1);
    localparam logic [CNT_W-1:0] WAIT_INIT = CNT_W'(LAT - 1);

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.state = ST_ADDR;
                    ctl_d.addr  = req_addr;
                end
            end
            ST_ADDR: begin
                ctl_d.state    = ST_WAIT;
                ctl_d.wait_cnt = WAIT_INIT;
            end
            ST_WAIT: begin
                if (ctl_q.wait_cnt == '0) begin
                    ctl_d.state = ST_XFER;
                    ctl_d.idx   = '0;
                end else begin
                    ctl_d.wait_cnt = ctl_q.wait_cnt - 1'b1;
                end
            end
            ST_XFER: begin
                ctl_d.idx = ctl_q.idx + 1'b1;
                if (ctl_q.idx == LAST_IDX) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.idx   = '0;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state    <= ST_IDLE;
            ctl_q.wait_cnt <= '0;
            ctl_q.idx      <= '0;
            ctl_q.addr     <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready     = (ctl_q.state == ST_IDLE);
    assign strobe    = (ctl_q.state == ST_ADDR);
    assign row_addr  = ctl_q.addr;
    assign xfer      = (ctl_q.state == ST_XFER);
    assign word_sel  = ctl_q.idx;
    assign last_word = xfer && (ctl_q.idx == LAST_IDX);
endmodule

// File: rtl/ilv_word_mux.sv
module ilv_word_mux #(
    parameter int DATA_W = 32,
    parameter int NBANK  = 4,
    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic [NBANK*DATA_W-1:0] bank_words,
    input  logic [IDX_W-1:0]        sel,
    output logic [DATA_W-1:0]       bus_word
);
    logic [DATA_W-1:0] lane [NBANK];

    for (genvar k = 0; k < NBANK; k++) begin : g_lane
        assign lane[k] = bank_words[k*DATA_W +: DATA_W];
    end

    always_comb begin
        bus_word = '0;
        for (int k = 0; k < NBANK; k++) begin
            if (sel == IDX_W'(k)) bus_word = lane[k];
        end
    end
endmodule

// File: rtl/ilv_block_fetch.sv
module ilv_block_fetch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int NBANK  = 4,
    parameter int LAT    = 15,
    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    ready,
    output logic                    bank_strobe,
    output logic [ADDR_W-1:0]       bank_addr,
    input  logic [NBANK*DATA_W-1:0] bank_rdata,
    output logic                    fill_valid,
    output logic [IDX_W-1:0]        fill_idx,
    output logic [DATA_W-1:0]       fill_data,
    output logic                    fill_done
);
    logic [IDX_W-1:0]  sel;
    logic [DATA_W-1:0] bus_word;
    logic              xfer;

    ilv_seq_ctrl #(
        .ADDR_W(ADDR_W), .NBANK(NBANK), .LAT(LAT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .ready     (ready),
        .strobe    (bank_strobe),
        .row_addr  (bank_addr),
        .xfer      (xfer),
        .word_sel  (sel),
        .last_word (fill_done)
    );

    ilv_word_mux #(
        .DATA_W(DATA_W), .NBANK(NBANK)
    ) u_mux (
        .bank_words (bank_rdata),
        .sel        (sel),
        .bus_word   (bus_word)
    );

    assign fill_valid = xfer;
    assign fill_idx   = sel;
    assign fill_data  = xfer ? bus_word : '0;
endmodule

// File: rtl/ilv_block_fetch_chk.sv
module ilv_block_fetch_chk #(
    parameter int ADDR_W = 16,
    parameter int NBANK  = 4,
    parameter int LAT    = 15,
    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int SW    = $clog2(LAT + 3) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              ready,
    input logic              bank_strobe,
    input logic [ADDR_W-1:0] bank_addr,
    input logic              fill_valid,
    input logic [IDX_W-1:0]  fill_idx,
    input logic              fill_done
);
    logic [SW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                          since_q <= '0;
        else if (bank_strobe)                since_q <= SW'(1);
        else if (since_q != SW'(LAT + 2))    since_q <= since_q + 1'b1;
    end

    // R2
    accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> bank_strobe);

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_strobe |=> !bank_strobe);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !bank_strobe) |-> $stable(bank_addr));

    // R4
    first_word_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_valid) |-> (since_q == SW'(LAT + 1)));

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_done) |=> (fill_valid && fill_idx == IDX_W'($past(fill_idx) + 1'b1)));

    // R7
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (fill_valid && fill_idx == IDX_W'(NBANK - 1)));

    // R9
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (ready && !fill_valid));
endmodule

bind ilv_block_fetch ilv_block_fetch_chk #(
    .ADDR_W(ADDR_W), .NBANK(NBANK), .LAT(LAT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .ready       (ready),
    .bank_strobe (bank_strobe),
    .bank_addr   (bank_addr),
    .fill_valid  (fill_valid),
    .fill_idx    (fill_idx),
    .fill_done   (fill_done)
);

// File: tb/tb_ilv_block_fetch.sv
module tb_ilv_block_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int NBANK  = 4;
    localparam int LAT    = 15;
    localparam int IDX_W  = 2;
    localparam int LAST_C = 1 + LAT + NBANK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic ready, bank_strobe, fill_valid, fill_done;
    logic [ADDR_W-1:0] bank_addr;
    logic [NBANK*DATA_W-1:0] bank_rdata;
    logic [IDX_W-1:0] fill_idx;
    logic [DATA_W-1:0] fill_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_block_fetch #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANK(NBANK), .LAT(LAT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .ready(ready), .bank_strobe(bank_strobe), .bank_addr(bank_addr),
        .bank_rdata(bank_rdata), .fill_valid(fill_valid), .fill_idx(fill_idx),
        .fill_data(fill_data), .fill_done(fill_done)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] blk, input int k);
        logic [31:0] wa;
        wa = 32'(blk) * 32'(NBANK) + 32'(k);
        return (wa * 32'h9E37_79B1) ^ 32'hC3A5_0F0F;
    endfunction

    // Bank models: shared row latch, data valid LAT cycles after the strobe edge
    logic [ADDR_W-1:0] bk_row = '0;
    int bk_cnt = 1;

    always @(posedge clk) begin
        if (bank_strobe) begin
            bk_row <= bank_addr;
            bk_cnt <= LAT;
        end else if (bk_cnt > 0) begin
            bk_cnt <= bk_cnt - 1;
        end
    end

    always_comb begin
        for (int k = 0; k < NBANK; k++) begin
            bank_rdata[k*DATA_W +: DATA_W] = (bk_cnt == 0) ? mem_word(bk_row, k)
                                                          : (32'hBAD0_0000 | 32'(k));
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts at a negedge with the DUT idle; returns at the negedge of the last word cycle.
    task automatic do_fetch(input logic [ADDR_W-1:0] blk, input bit busy_noise);
        chk(ready == 1'b1, "R9 ready before request", ready, 1);
        req_valid = 1'b1;
        req_addr  = blk;
        for (int c = 1; c <= LAST_C; c++) begin
            @(negedge clk);
            chk(bank_strobe == (c == 1), "R2 strobe", bank_strobe, c == 1);
            chk(bank_addr == blk, "R3 bank_addr", bank_addr, blk);
            chk(ready == 1'b0, "R9 busy", ready, 0);
            chk(fill_valid == (c > 1 + LAT), "R4 R6 fill_valid timing", fill_valid, c > 1 + LAT);
            chk(fill_done == (c == LAST_C), "R7 fill_done", fill_done, c == LAST_C);
            if (c > 1 + LAT) begin
                chk(fill_idx == IDX_W'(c - 2 - LAT), "R5 fill_idx", fill_idx, c - 2 - LAT);
                chk(fill_data == mem_word(blk, c - 2 - LAT), "R5 fill_data",
                    fill_data, mem_word(blk, c - 2 - LAT));
            end
            if (busy_noise && c < LAST_C) begin
                req_valid = 1'b1;
                req_addr  = blk ^ 16'h5A5A ^ ADDR_W'(c);
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    task automatic test_reset();
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(bank_strobe == 1'b0, "R1 strobe", bank_strobe, 0);
        chk(fill_valid == 1'b0, "R1 fill_valid", fill_valid, 0);
        chk(fill_done == 1'b0, "R1 fill_done", fill_done, 0);
    endtask

    task automatic test_quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!bank_strobe && !fill_valid && ready, tag,
                {bank_strobe, fill_valid, ready}, 3'b001);
        end
    endtask

    task automatic test_basic();
        do_fetch(16'h0005, 1'b0);
        test_quiet(3, "R2 idle without request");
    endtask

    task automatic test_busy_ignored();
        do_fetch(16'h1234, 1'b1);
        test_quiet(25, "R8 no extra fetch after busy requests");
    endtask

    task automatic test_back_to_back();
        do_fetch(16'hFFFF, 1'b0);
        @(negedge clk);
        do_fetch(16'h0000, 1'b0);
        @(negedge clk);
        do_fetch(16'h8001, 1'b0);
        @(negedge clk);
        test_quiet(2, "R9 idle after chain");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        @(negedge clk);
        test_basic();
        test_busy_ignored();
        test_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule